// File: doc/BRIEF.md
# Byte-Bus Multiply/Divide Coprocessor

This block is an arithmetic helper that hangs off an 8-bit register bus. Software loads operands one byte at a time. It then starts an operation by writing a single trigger byte and later reads the answer back one byte at a time. Two operations are offered. The first is an unsigned 16×16 multiply with a 32-bit product. The second is an unsigned 32÷16 divide that returns a 32-bit quotient and a 16-bit remainder.

Both operations share the same input and output byte slots. The low half of the dividend doubles as the multiplicand, and the product and the quotient land in the same four result bytes. The work is done iteratively, one bit per clock. A status byte tells software whether the engine is still working. Writing to a dedicated clear address wipes the whole register bank.

Register addresses (4-bit): 0–3 dividend (byte 0 least significant; bytes 0–1 are also the multiplicand), 4–5 multiplier, 6–7 divisor, 8–11 product/quotient, 12–13 remainder, 14 clear (write-only, reads 0), 15 status. All multi-byte values are stored low byte first.

Top module: `muldiv_regbank`

## Requirements
- R1: Writing one of addresses 0–7 stores the data byte in that slot, and reading the same address returns it. Bytes 0–1 form the multiplicand, bytes 0–3 form the dividend, bytes 4–5 form the multiplier and bytes 6–7 form the divisor. In every case the byte at the lower address is the less significant one.
- R2: A write to address 5 starts an unsigned multiply of {byte1,byte0} × {byte5,byte4}. The 32-bit product appears at addresses 8–11, low byte first, on the 16th rising edge after the starting write's edge. The remainder bytes are left unchanged.
- R3: A write to address 7 starts an unsigned divide of bytes 0–3 by {byte7,byte6}. On the 32nd rising edge after the starting write, the quotient appears at 8–11 and the remainder at 12–13, both low byte first.
- R4: Status (address 15) reads 0x80 from the starting write's edge until the result edge, and reads 0x00 otherwise.
- R5: Result bytes 8–13 keep their previous values until the completing edge.
- R6: A write of any value to address 14 sets every operand and result byte to 0x00 and abandons any operation in progress. After that write, status reads 0x00 and no late result appears.
- R7: After reset, every readable address returns 0x00.
- R8: With a zero divisor, the quotient is 0xFFFFFFFF and the remainder equals the low 16 bits of the dividend.
- R9: A start write while busy restarts the engine with the current operands. The full latency is then counted from the new write, and the earlier operation never delivers a result.
- R10: Operands are captured at the start write. Writing operand bytes while busy changes what is read back but not the result of the running operation.
- R11: Writes to addresses 8–13 and 15 are ignored, and address 14 always reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 4 | Register address of the write |
| wr_data | input | 8 | Byte written |
| rd_addr | input | 4 | Register address to read |
| rd_data | output | 8 | Byte at rd_addr (combinational) |

## Verification
The multiply is tried with a mid-range pair and with the all-ones pair. The all-ones case separates a correct carry out of the add stage from a truncated one. The divide is tried with a wide dividend over a small divisor, a dividend smaller than the divisor, an all-ones case and a zero divisor. These separate quotient bit ordering, remainder restore and the defined zero-divisor answer. Further sequences cover a restart partway through, operand rewrites during a divide, a clear in mid-operation and writes to read-only slots. Each of these tells apart the capture and priority rules from a design that reads live operands or lets an abandoned operation finish.

// File: rtl/muldiv_pkg.sv
// Package: shared constants and types for the multiply/divide register bank.
// Assumes an 8-bit register bus.
package muldiv_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } op_e;
endpackage

// File: rtl/muldiv_operands.sv
// Module: operand byte store. It holds dividend/multiplicand, multiplier
// and divisor, and decodes the two start triggers. It also presents the
// value each register takes after the current write, so that the engine
// can capture a start operand in the same cycle it is written.
// Assumes at most one write per cycle and that clr is exclusive with any
// other write address.
module muldiv_operands
    import muldiv_pkg::*;
#(
    parameter int OP_W   = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              clr,
    output logic [2*OP_W-1:0] dvd_q,
    output logic [OP_W-1:0]   mpr_q,
    output logic [OP_W-1:0]   dvs_q,
    output logic [2*OP_W-1:0] dvd_nx,
    output logic [OP_W-1:0]   mpr_nx,
    output logic [OP_W-1:0]   dvs_nx,
    output logic              mul_start,
    output logic              div_start
);
    localparam int OB    = OP_W / BYTE_W;
    localparam int A_DVD = 0;
    localparam int A_MPR = 2 * OB;
    localparam int A_DVS = 3 * OB;

    // Next value of each operand register after this cycle's write or clear.
    always_comb begin
        dvd_nx = dvd_q;
        mpr_nx = mpr_q;
        dvs_nx = dvs_q;
        if (clr) begin
            dvd_nx = '0;
            mpr_nx = '0;
            dvs_nx = '0;
        end else if (wr_en) begin
            for (int i = 0; i < 2 * OB; i++)
                if (wr_addr == ADDR_W'(A_DVD + i)) dvd_nx[i*BYTE_W +: BYTE_W] = wr_data;
            for (int i = 0; i < OB; i++) begin
                if (wr_addr == ADDR_W'(A_MPR + i)) mpr_nx[i*BYTE_W +: BYTE_W] = wr_data;
                if (wr_addr == ADDR_W'(A_DVS + i)) dvs_nx[i*BYTE_W +: BYTE_W] = wr_data;
            end
        end
    end

    // Operand registers follow their next values; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            mpr_q <= '0;
            dvs_q <= '0;
        end else begin
            dvd_q <= dvd_nx;
            mpr_q <= mpr_nx;
            dvs_q <= dvs_nx;
        end
    end

    // Start triggers: a write to the top byte of the multiplier or divisor.
    assign mul_start = wr_en && (wr_addr == ADDR_W'(A_MPR + OB - 1));
    assign div_start = wr_en && (wr_addr == ADDR_W'(A_DVS + OB - 1));
endmodule

// File: rtl/muldiv_engine.sv
// Module: iterative arithmetic engine. It does shift-add multiply
// (OP_W steps) and restoring division (2*OP_W steps), one bit per clock.
// It captures operands on a start pulse, and a start while busy reloads.
// done is high in the cycle whose edge finishes the operation; res_nx and
// rem_nx hold the final values in that cycle.
// Assumes mul_start and div_start are never high together.
module muldiv_engine
    import muldiv_pkg::*;
#(
    parameter int OP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              mul_start,
    input  logic              div_start,
    input  logic [OP_W-1:0]   mcand,
    input  logic [OP_W-1:0]   mplier,
    input  logic [2*OP_W-1:0] dividend,
    input  logic [OP_W-1:0]   divisor,
    output logic              busy,
    output logic              done,
    output logic              rem_load,
    output logic [2*OP_W-1:0] res_nx,
    output logic [OP_W-1:0]   rem_nx
);
    localparam int DVD_W = 2 * OP_W;
    localparam int CNT_W = $clog2(DVD_W);

    op_e              op_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DVD_W-1:0] acc_q;
    logic [OP_W-1:0]  rem_q;
    logic [OP_W-1:0]  opnd_q;
    logic [OP_W:0]    hi_sum;
    logic [OP_W:0]    trial;
    logic [OP_W:0]    diff;
    logic             ge;
    logic [CNT_W-1:0] last_cnt;

    // One iteration step for the current operation.
    always_comb begin
        hi_sum = {1'b0, acc_q[DVD_W-1:OP_W]} + (acc_q[0] ? {1'b0, opnd_q} : '0);
        trial  = {rem_q, acc_q[DVD_W-1]};
        ge     = trial >= {1'b0, opnd_q};
        diff   = trial - {1'b0, opnd_q};
        if (op_q == OP_MUL) begin
            res_nx = {hi_sum, acc_q[OP_W-1:1]};
            rem_nx = rem_q;
        end else begin
            res_nx = {acc_q[DVD_W-2:0], ge};
            rem_nx = ge ? diff[OP_W-1:0] : trial[OP_W-1:0];
        end
    end

    assign last_cnt = (op_q == OP_MUL) ? CNT_W'(OP_W - 1) : CNT_W'(DVD_W - 1);
    assign busy     = (cnt_q != '0) || busy_q;
    assign done     = busy_q && (cnt_q == last_cnt) && !mul_start && !div_start && !clr;
    assign rem_load = done && (op_q == OP_DIV);

    logic busy_q;

    // Sequencer: load on start, step while busy, stop on done or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy_q <= 1'b0;
            op_q   <= OP_MUL;
            cnt_q  <= '0;
            acc_q  <= '0;
            rem_q  <= '0;
            opnd_q <= '0;
        end else if (mul_start) begin
            busy_q <= 1'b1;
            op_q   <= OP_MUL;
            cnt_q  <= '0;
            acc_q  <= {{OP_W{1'b0}}, mplier};
            rem_q  <= '0;
            opnd_q <= mcand;
        end else if (div_start) begin
            busy_q <= 1'b1;
            op_q   <= OP_DIV;
            cnt_q  <= '0;
            acc_q  <= dividend;
            rem_q  <= '0;
            opnd_q <= divisor;
        end else if (busy_q) begin
            acc_q <= res_nx;
            rem_q <= rem_nx;
            if (cnt_q == last_cnt) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/muldiv_regbank.sv
// Module: top of the multiply/divide register bank. It holds the result
// registers, decodes the clear address and drives the combinational read
// mux. Address map derives from OP_W: operands, results, clear, status.
// Assumes a single-port byte write and an independent read address.
module muldiv_regbank
    import muldiv_pkg::*;
#(
    parameter int OP_W   = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int OB     = OP_W / BYTE_W;
    localparam int DVD_W  = 2 * OP_W;
    localparam int A_DVD  = 0;
    localparam int A_MPR  = 2 * OB;
    localparam int A_DVS  = 3 * OB;
    localparam int A_RES  = 4 * OB;
    localparam int A_REM  = 6 * OB;
    localparam int A_CLR  = 7 * OB;
    localparam int A_STAT = 7 * OB + 1;

    logic              clr;
    logic [DVD_W-1:0]  dvd_q, dvd_nx;
    logic [OP_W-1:0]   mpr_q, mpr_nx, dvs_q, dvs_nx;
    logic              mul_start, div_start;
    logic              eng_busy, eng_done, eng_rem_load;
    logic [DVD_W-1:0]  eng_res;
    logic [OP_W-1:0]   eng_rem;
    logic [DVD_W-1:0]  res_q;
    logic [OP_W-1:0]   rem_res_q;

    assign clr = wr_en && (wr_addr == ADDR_W'(A_CLR));

    muldiv_operands #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_opnd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .clr       (clr),
        .dvd_q     (dvd_q),
        .mpr_q     (mpr_q),
        .dvs_q     (dvs_q),
        .dvd_nx    (dvd_nx),
        .mpr_nx    (mpr_nx),
        .dvs_nx    (dvs_nx),
        .mul_start (mul_start),
        .div_start (div_start)
    );

    muldiv_engine #(.OP_W(OP_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .mul_start (mul_start),
        .div_start (div_start),
        .mcand     (dvd_nx[OP_W-1:0]),
        .mplier    (mpr_nx),
        .dividend  (dvd_nx),
        .divisor   (dvs_nx),
        .busy      (eng_busy),
        .done      (eng_done),
        .rem_load  (eng_rem_load),
        .res_nx    (eng_res),
        .rem_nx    (eng_rem)
    );

    // Result registers: load only on completion; clear and reset zero them.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            res_q     <= '0;
            rem_res_q <= '0;
        end else if (eng_done) begin
            res_q <= eng_res;
            if (eng_rem_load) rem_res_q <= eng_rem;
        end
    end

    // Read mux: byte select over operands, results and status.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < 2 * OB; i++) begin
            if (rd_addr == ADDR_W'(A_DVD + i)) rd_data = dvd_q[i*BYTE_W +: BYTE_W];
            if (rd_addr == ADDR_W'(A_RES + i)) rd_data = res_q[i*BYTE_W +: BYTE_W];
        end
        for (int i = 0; i < OB; i++) begin
            if (rd_addr == ADDR_W'(A_MPR + i)) rd_data = mpr_q[i*BYTE_W +: BYTE_W];
            if (rd_addr == ADDR_W'(A_DVS + i)) rd_data = dvs_q[i*BYTE_W +: BYTE_W];
            if (rd_addr == ADDR_W'(A_REM + i)) rd_data = rem_res_q[i*BYTE_W +: BYTE_W];
        end
        if (rd_addr == ADDR_W'(A_STAT)) rd_data = {eng_busy, {(BYTE_W-1){1'b0}}};
    end
endmodule

// File: rtl/muldiv_checker.sv
// Module: protocol checker for muldiv_regbank, attached by bind.
// Assumes the address map of the top module (derived from OP_W).
module muldiv_checker #(
    parameter int OP_W   = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              busy,
    input logic              done,
    input logic [2*OP_W-1:0] prod,
    input logic [OP_W-1:0]   rem
);
    localparam int OB     = OP_W / 8;
    localparam int DVD_W  = 2 * OP_W;
    localparam int A_MHI  = 3 * OB - 1;
    localparam int A_DHI  = 4 * OB - 1;
    localparam int A_CLR  = 7 * OB;
    localparam int LAT_W  = $clog2(DVD_W) + 2;

    logic             start_w, clr_w;
    logic [LAT_W-1:0] lat_cnt;

    assign start_w = wr_en && (wr_addr == ADDR_W'(A_MHI) || wr_addr == ADDR_W'(A_DHI));
    assign clr_w   = wr_en && (wr_addr == ADDR_W'(A_CLR));

    // Count busy cycles since the latest start.
    always_ff @(posedge clk) begin
        if (!rst_n || start_w || !busy) lat_cnt <= '0;
        else                            lat_cnt <= lat_cnt + 1'b1;
    end

    // R4: a start write makes the block busy at the next sample.
    p_busy_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> busy);

    // R6: a clear write leaves the block idle with zeroed results.
    p_clear_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> (!busy && prod == '0 && rem == '0));

    // R5: results change only on a completing edge (or a clear).
    p_hold_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !clr_w) |=> ($stable(prod) && $stable(rem)));

    // R3: no operation stays busy beyond the divide latency.
    p_bounded_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lat_cnt < LAT_W'(DVD_W)));

    // R2: a completing edge without a new start leaves the block idle.
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_w) |=> !busy);
endmodule

bind muldiv_regbank muldiv_checker #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .busy    (eng_busy),
    .done    (eng_done),
    .prod    (res_q),
    .rem     (rem_res_q)
);

// File: tb/muldiv_regbank_tb.sv
module muldiv_regbank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    muldiv_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    // Behavioural reference model, updated on every rising edge.
    logic [7:0]  m_reg [16];
    bit          m_busy;
    bit          m_div;
    int          m_left;
    logic [31:0] m_dvd;
    logic [15:0] m_a, m_b;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_reg[i]) m_reg[i] = 8'h00;
            m_busy = 0; m_left = 0;
        end else if (wr_en && wr_addr == 4'd14) begin
            foreach (m_reg[i]) m_reg[i] = 8'h00;
            m_busy = 0; m_left = 0;
        end else begin
            if (wr_en && wr_addr < 4'd8) m_reg[wr_addr] = wr_data;
            if (wr_en && (wr_addr == 4'd5 || wr_addr == 4'd7)) begin
                m_div  = (wr_addr == 4'd7);
                m_left = m_div ? 32 : 16;
                m_busy = 1;
                m_dvd  = {m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
                m_a    = {m_reg[1], m_reg[0]};
                m_b    = m_div ? {m_reg[7], m_reg[6]} : {m_reg[5], m_reg[4]};
            end else if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    logic [31:0] r32;
                    logic [15:0] r16;
                    m_busy = 0;
                    if (!m_div) begin
                        r32 = 32'(m_a) * 32'(m_b);
                    end else if (m_b == 16'h0) begin
                        r32 = 32'hFFFF_FFFF; r16 = m_dvd[15:0];
                        m_reg[12] = r16[7:0]; m_reg[13] = r16[15:8];
                    end else begin
                        r32 = m_dvd / 32'(m_b); r16 = 16'(m_dvd % 32'(m_b));
                        m_reg[12] = r16[7:0]; m_reg[13] = r16[15:8];
                    end
                    for (int i = 0; i < 4; i++) m_reg[8+i] = r32[i*8 +: 8];
                end
            end
        end
    end

    function automatic logic [7:0] m_read(input logic [3:0] a);
        if (a < 4'd14) return m_reg[a];
        if (a == 4'd15) return {m_busy, 7'b0};
        return 8'h00;
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        if (a < 4'd8)  return "R1";
        if (a < 4'd14) return "R5";
        if (a == 4'd15) return "R4";
        return "R11";
    endfunction

    // Per-clock comparison of the addressed byte against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (rd_data !== m_read(rd_addr)) begin
                errors++;
                $display("FAIL %s model compare addr %0d: actual %02h expected %02h",
                         tag_of(rd_addr), rd_addr, rd_data, m_read(rd_addr));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #2;
        wr_en = 1'b0;
    endtask

    task automatic expect_b(input string tag, input logic [3:0] a, input logic [7:0] e);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== e) begin
            errors++;
            $display("FAIL %s addr %0d: actual %02h expected %02h", tag, a, rd_data, e);
        end
    endtask

    task automatic expect_res(input string tag, input logic [31:0] q);
        for (int i = 0; i < 4; i++) expect_b(tag, 4'(8 + i), q[i*8 +: 8]);
    endtask

    task automatic expect_rem(input string tag, input logic [15:0] r);
        expect_b(tag, 4'd12, r[7:0]);
        expect_b(tag, 4'd13, r[15:8]);
    endtask

    task automatic set_dvd(input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(4'(i), v[i*8 +: 8]);
    endtask

    task automatic start_div(input logic [15:0] d);
        wr(4'd6, d[7:0]);
        wr(4'd7, d[15:8]);
    endtask

    task automatic start_mul(input logic [15:0] a, input logic [15:0] b);
        wr(4'd0, a[7:0]); wr(4'd1, a[15:8]);
        wr(4'd4, b[7:0]); wr(4'd5, b[15:8]);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R7: reset state
        for (int a = 0; a < 16; a++) expect_b("R7", 4'(a), 8'h00);

        // R1: operand bytes read back
        wr(4'd0, 8'h78); wr(4'd1, 8'h56); wr(4'd2, 8'h34); wr(4'd3, 8'h12);
        wr(4'd4, 8'hCD); wr(4'd6, 8'h42);
        expect_b("R1", 4'd0, 8'h78); expect_b("R1", 4'd3, 8'h12);
        expect_b("R1", 4'd4, 8'hCD); expect_b("R1", 4'd6, 8'h42);

        // R2/R4/R5: mid-range multiply and its latency
        start_mul(16'h1234, 16'hABCD);
        expect_b("R4", 4'd15, 8'h80);
        tick(15);
        expect_b("R4", 4'd15, 8'h80);
        expect_res("R5", 32'h0);
        tick(1);
        expect_res("R2", 32'h1234 * 32'hABCD);
        expect_rem("R2", 16'h0);
        expect_b("R4", 4'd15, 8'h00);

        // R2: all-ones multiply
        start_mul(16'hFFFF, 16'hFFFF);
        tick(16);
        expect_res("R2", 32'hFFFE_0001);

        // R3/R5: wide dividend, small divisor
        set_dvd(32'h1234_5678);
        start_div(16'h00FF);
        tick(31);
        expect_b("R4", 4'd15, 8'h80);
        expect_res("R5", 32'hFFFE_0001);
        tick(1);
        expect_res("R3", 32'h1234_5678 / 32'hFF);
        expect_rem("R3", 16'(32'h1234_5678 % 32'hFF));

        // R3: dividend below divisor
        set_dvd(32'h5);
        start_div(16'h0100);
        tick(32);
        expect_res("R3", 32'h0);
        expect_rem("R3", 16'h5);

        // R3: all-ones divide
        set_dvd(32'hFFFF_FFFF);
        start_div(16'hFFFF);
        tick(32);
        expect_res("R3", 32'h0001_0001);
        expect_rem("R3", 16'h0);

        // R8: zero divisor
        set_dvd(32'hDEAD_BEEF);
        start_div(16'h0000);
        tick(32);
        expect_res("R8", 32'hFFFF_FFFF);
        expect_rem("R8", 16'hBEEF);

        // R9: restart while busy with a new multiplier
        start_mul(16'h0003, 16'h0005);
        tick(6);
        wr(4'd4, 8'h07);
        wr(4'd5, 8'h00);
        tick(15);
        expect_b("R9", 4'd15, 8'h80);
        expect_res("R9", 32'hFFFF_FFFF);
        tick(1);
        expect_res("R9", 32'd21);
        expect_b("R9", 4'd15, 8'h00);

        // R10: operand rewrites during a divide do not disturb it
        set_dvd(32'd1000);
        start_div(16'd7);
        for (int i = 0; i < 4; i++) wr(4'(i), 8'h99);
        expect_b("R10", 4'd2, 8'h99);
        tick(28);
        expect_res("R10", 32'd142);
        expect_rem("R10", 16'd6);

        // R6: clear in mid-operation
        start_mul(16'h1111, 16'h2222);
        tick(5);
        wr(4'd14, 8'h5A);
        for (int a = 0; a < 14; a++) expect_b("R6", 4'(a), 8'h00);
        expect_b("R6", 4'd15, 8'h00);
        tick(20);
        expect_b("R6", 4'd15, 8'h00);
        expect_res("R6", 32'h0);

        // R11: read-only slots ignore writes
        start_mul(16'd2, 16'd3);
        tick(16);
        wr(4'd8, 8'hEE); wr(4'd9, 8'hEE); wr(4'd13, 8'hEE); wr(4'd15, 8'hFF);
        expect_res("R11", 32'd6);
        expect_b("R11", 4'd13, 8'h00);
        expect_b("R11", 4'd15, 8'h00);
        expect_b("R11", 4'd14, 8'h00);

        tick(2);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule